// File: doc/BRIEF.md
# Multicycle Byte-Fetch Processor Controller

This block is the control state machine of a small 8-bit multicycle processor. The processor runs a 32-bit instruction subset over an 8-bit memory port, so each instruction word is gathered one byte per cycle. The controller sequences four fetch cycles that fill the instruction register byte by byte while the program counter advances by one each cycle. It then decodes the 6-bit opcode held in the instruction register and steps through a short sequence for the instruction class: byte load, byte store, register-to-register arithmetic, branch-if-equal or jump.

The datapath, register file, ALU function decoding and memory sit outside this block. The controller drives their selects and enables. Every control output is registered, and it always matches the state code reported on `state_o`. The opcode is sampled in the decode state, and again in the address state to choose between load and store.

Top module: `mcyc_ctrl`

## Requirements
- R1: Reset is synchronous and active high. The edge after which `rst` is high leaves `state_o` = 0 (fetch byte 0) and the outputs at their fetch-byte-0 values.
- R2: In each fetch state (codes 0 to 3), whatever the opcode, the outputs are: `mem_rd`=1, `addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=01, `alu_op`=00, `pc_we`=1, `pc_src`=00. The state then moves to the next code, and from code 3 to decode (code 4).
- R3: `ir_we` has exactly one bit set in each fetch state. Bit 0 is set in code 0, bit 1 in code 1, bit 2 in code 2 and bit 3 in code 3. Outside fetch, `ir_we` is 0.
- R4: Decode (code 4) drives `alu_a_sel`=0, `alu_b_sel`=11 and `alu_op`=00. It branches on the opcode: 100000 (load byte) or 101000 (store byte) go to address computation (5), 000000 (register type) to execute (9), 000100 (branch-equal) to branch (11), and 000010 (jump) to jump (12).
- R5: Address computation (code 5) drives `alu_a_sel`=1, `alu_b_sel`=10 and `alu_op`=00. It goes to load access (6) if the opcode at that time is 100000, or to store access (8) if it is 101000.
- R6: Load access (6) drives `mem_rd`=1 and `addr_sel`=1. It is followed by load write-back (7), which drives `rf_we`=1, `dst_sel`=0 and `wb_sel`=1.
- R7: Store access (8) drives `mem_wr`=1 and `addr_sel`=1. `mem_rd` and `mem_wr` are never high together.
- R8: Execute (9) drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10. It is followed by register completion (10), which drives `rf_we`=1, `dst_sel`=1 and `wb_sel`=0.
- R9: Branch (11) drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01, `pc_we_cond`=1 and `pc_src`=01, with `pc_we`=0.
- R10: Jump (12) drives `pc_we`=1 and `pc_src`=10.
- R11: States 7, 8, 10, 11 and 12 return to fetch byte 0 on the next clock. Decode also returns to fetch byte 0 when it sees an opcode not listed in R4.
- R12: In every state, any output that the requirement for that state does not name is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| state_o | output | 4 | Current state code |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU result |
| ir_we | output | 4 | Per-byte instruction register write enables |
| pc_we | output | 1 | Unconditional program counter write |
| pc_we_cond | output | 1 | Program counter write when the ALU reports equal |
| pc_src | output | 2 | Program counter source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_a_sel | output | 1 | ALU operand A: 0 program counter, 1 register |
| alu_b_sel | output | 2 | ALU operand B: 00 register, 01 constant one, 10 immediate, 11 branch offset |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| dst_sel | output | 1 | Register destination: 0 rb field, 1 rd field |
| rf_we | output | 1 | Register file write enable |
| wb_sel | output | 1 | Write-back source: 0 ALU result, 1 memory data |

## Verification
The main table runs each instruction class back to back without reset in between: load, store, register type, branch, jump and two unlisted opcodes. The bench checks every state on each path together with all outputs, so a wrong branch target, a wrong byte enable or a stray output shows up in the state where it occurs. Directed tests then change the opcode during fetch, which separates a fetch sequence that is truly independent of the opcode from one that leaks it. They also switch the opcode in the address state, which shows where the load/store choice is made, and they assert reset in the middle of a sequence.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int OP_W     = 6;
  localparam int IR_BYTES = 4;
  localparam int ST_W     = 4;

  typedef enum logic [ST_W-1:0] {
    S_FB0   = 4'd0,
    S_FB1   = 4'd1,
    S_FB2   = 4'd2,
    S_FB3   = 4'd3,
    S_DEC   = 4'd4,
    S_ADDR  = 4'd5,
    S_LDACC = 4'd6,
    S_LDWB  = 4'd7,
    S_STACC = 4'd8,
    S_REXE  = 4'd9,
    S_RWB   = 4'd10,
    S_BRCH  = 4'd11,
    S_JUMP  = 4'd12
  } state_t;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_JMP   = 6'b000010;
  localparam logic [OP_W-1:0] OPC_LB    = 6'b100000;
  localparam logic [OP_W-1:0] OPC_SB    = 6'b101000;

  localparam logic [1:0] PCS_ALU    = 2'd0;
  localparam logic [1:0] PCS_ALUREG = 2'd1;
  localparam logic [1:0] PCS_JT     = 2'd2;

  localparam logic [1:0] BSEL_REG = 2'd0;
  localparam logic [1:0] BSEL_ONE = 2'd1;
  localparam logic [1:0] BSEL_IMM = 2'd2;
  localparam logic [1:0] BSEL_OFF = 2'd3;

  localparam logic [1:0] AOP_ADD = 2'd0;
  localparam logic [1:0] AOP_SUB = 2'd1;
  localparam logic [1:0] AOP_FN  = 2'd2;

  typedef struct packed {
    logic                mem_rd;
    logic                mem_wr;
    logic                addr_sel;
    logic [IR_BYTES-1:0] ir_we;
    logic                pc_we;
    logic                pc_we_cond;
    logic [1:0]          pc_src;
    logic                alu_a_sel;
    logic [1:0]          alu_b_sel;
    logic [1:0]          alu_op;
    logic                dst_sel;
    logic                rf_we;
    logic                wb_sel;
  } ctrl_t;
endpackage

// File: rtl/mcc_next.sv
module mcc_next
  import mcc_pkg::*;
(
  input  state_t              cur,
  input  logic [OP_W-1:0]     opcode,
  output state_t              nxt
);
  localparam state_t LAST_FETCH = state_t'(ST_W'(IR_BYTES - 1));

  always_comb begin
    nxt = S_FB0;
    if (cur == S_DEC) begin
      case (opcode)
        OPC_LB, OPC_SB: nxt = S_ADDR;
        OPC_RTYPE:      nxt = S_REXE;
        OPC_BEQ:        nxt = S_BRCH;
        OPC_JMP:        nxt = S_JUMP;
        default:        nxt = S_FB0;
      endcase
    end else if (cur == S_ADDR) begin
      if (opcode == OPC_LB)      nxt = S_LDACC;
      else if (opcode == OPC_SB) nxt = S_STACC;
      else                       nxt = S_FB0;
    end else if (cur == LAST_FETCH) begin
      nxt = S_DEC;
    end else if (cur < LAST_FETCH) begin
      nxt = state_t'(cur + 1'b1);
    end else begin
      case (cur)
        S_LDACC: nxt = S_LDWB;
        S_REXE:  nxt = S_RWB;
        default: nxt = S_FB0;
      endcase
    end
  end
endmodule

// File: rtl/mcc_decode.sv
module mcc_decode
  import mcc_pkg::*;
(
  input  state_t st,
  output ctrl_t  c
);
  always_comb begin
    c = '0;
    for (int i = 0; i < IR_BYTES; i++) begin
      c.ir_we[i] = (st == state_t'(ST_W'(i)));
    end
    case (st)
      S_FB0, S_FB1, S_FB2, S_FB3: begin
        c.mem_rd    = 1'b1;
        c.alu_b_sel = BSEL_ONE;
        c.alu_op    = AOP_ADD;
        c.pc_we     = 1'b1;
        c.pc_src    = PCS_ALU;
      end
      S_DEC: begin
        c.alu_b_sel = BSEL_OFF;
        c.alu_op    = AOP_ADD;
      end
      S_ADDR: begin
        c.alu_a_sel = 1'b1;
        c.alu_b_sel = BSEL_IMM;
        c.alu_op    = AOP_ADD;
      end
      S_LDACC: begin
        c.mem_rd   = 1'b1;
        c.addr_sel = 1'b1;
      end
      S_LDWB: begin
        c.rf_we  = 1'b1;
        c.wb_sel = 1'b1;
      end
      S_STACC: begin
        c.mem_wr   = 1'b1;
        c.addr_sel = 1'b1;
      end
      S_REXE: begin
        c.alu_a_sel = 1'b1;
        c.alu_b_sel = BSEL_REG;
        c.alu_op    = AOP_FN;
      end
      S_RWB: begin
        c.rf_we   = 1'b1;
        c.dst_sel = 1'b1;
      end
      S_BRCH: begin
        c.alu_a_sel  = 1'b1;
        c.alu_b_sel  = BSEL_REG;
        c.alu_op     = AOP_SUB;
        c.pc_we_cond = 1'b1;
        c.pc_src     = PCS_ALUREG;
      end
      S_JUMP: begin
        c.pc_we  = 1'b1;
        c.pc_src = PCS_JT;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcc_pkg::*;
#(
  parameter int OPW   = OP_W,
  parameter int NBYTE = IR_BYTES,
  parameter int SW    = ST_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPW-1:0]   opcode,
  output logic [SW-1:0]    state_o,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             addr_sel,
  output logic [NBYTE-1:0] ir_we,
  output logic             pc_we,
  output logic             pc_we_cond,
  output logic [1:0]       pc_src,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_op,
  output logic             dst_sel,
  output logic             rf_we,
  output logic             wb_sel
);
  state_t state_q;
  state_t nxt_raw;
  state_t nxt_eff;
  ctrl_t  ctrl_nxt;
  ctrl_t  ctrl_q;

  mcc_next u_next (
    .cur    (state_q),
    .opcode (opcode),
    .nxt    (nxt_raw)
  );

  assign nxt_eff = rst ? S_FB0 : nxt_raw;

  // Outputs decoded from the next state and registered, so they line up with state_q.
  mcc_decode u_dec (
    .st (nxt_eff),
    .c  (ctrl_nxt)
  );

  always_ff @(posedge clk) begin
    state_q <= nxt_eff;
    ctrl_q  <= ctrl_nxt;
  end

  assign state_o    = state_q;
  assign mem_rd     = ctrl_q.mem_rd;
  assign mem_wr     = ctrl_q.mem_wr;
  assign addr_sel   = ctrl_q.addr_sel;
  assign ir_we      = ctrl_q.ir_we;
  assign pc_we      = ctrl_q.pc_we;
  assign pc_we_cond = ctrl_q.pc_we_cond;
  assign pc_src     = ctrl_q.pc_src;
  assign alu_a_sel  = ctrl_q.alu_a_sel;
  assign alu_b_sel  = ctrl_q.alu_b_sel;
  assign alu_op     = ctrl_q.alu_op;
  assign dst_sel    = ctrl_q.dst_sel;
  assign rf_we      = ctrl_q.rf_we;
  assign wb_sel     = ctrl_q.wb_sel;
endmodule

// File: rtl/mcc_ctrl_chk.sv
module mcc_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] state_o,
  input logic [3:0] ir_we,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       pc_we,
  input logic       pc_we_cond,
  input logic [1:0] pc_src,
  input logic       rf_we,
  input logic       wb_sel
);
  p_reset_r1: assert property (@(posedge clk) rst |=> state_o == 4'd0);

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (rst)
    state_o < 4'd3 |=> state_o == $past(state_o) + 4'd1);

  p_ir_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    state_o < 4'd4 |-> $countones(ir_we) == 1 && ir_we[state_o[1:0]]);

  p_ir_idle_r3: assert property (@(posedge clk) disable iff (rst)
    state_o >= 4'd4 |-> ir_we == 4'd0);

  p_wb_follows_r6: assert property (@(posedge clk) disable iff (rst)
    state_o == 4'd6 |=> rf_we && wb_sel);

  p_rw_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_cond_pc_r9: assert property (@(posedge clk) disable iff (rst)
    pc_we_cond |-> pc_src == 2'b01 && !pc_we);

  p_done_fetch_r11: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd7 || state_o == 4'd8 || state_o == 4'd10 ||
     state_o == 4'd11 || state_o == 4'd12) |=> state_o == 4'd0);
endmodule

bind mcyc_ctrl mcc_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .state_o    (state_o),
  .ir_we      (ir_we),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .pc_we      (pc_we),
  .pc_we_cond (pc_we_cond),
  .pc_src     (pc_src),
  .rf_we      (rf_we),
  .wb_sel     (wb_sel)
);

// File: tb/mcyc_ctrl_tb.sv
module mcyc_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic [3:0] state_o;
  logic       mem_rd, mem_wr, addr_sel, pc_we, pc_we_cond;
  logic [3:0] ir_we;
  logic [1:0] pc_src, alu_b_sel, alu_op;
  logic       alu_a_sel, dst_sel, rf_we, wb_sel;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  mcyc_ctrl u_dut (
    .clk(clk), .rst(rst), .opcode(opcode), .state_o(state_o),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_we(ir_we),
    .pc_we(pc_we), .pc_we_cond(pc_we_cond), .pc_src(pc_src),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .dst_sel(dst_sel), .rf_we(rf_we), .wb_sel(wb_sel)
  );

  logic [18:0] act_ctrl;
  assign act_ctrl = {mem_rd, mem_wr, addr_sel, ir_we, pc_we, pc_we_cond, pc_src,
                     alu_a_sel, alu_b_sel, alu_op, dst_sel, rf_we, wb_sel};

  // Expected outputs per state code, taken from R2..R12.
  function automatic logic [18:0] exp_ctrl(input logic [3:0] s);
    logic rd = 0, wr = 0, as = 0, pw = 0, pwc = 0, a = 0, d = 0, rw = 0, wb = 0;
    logic [3:0] ir = 0;
    logic [1:0] ps = 0, b = 0, op = 0;
    if (s < 4'd4) begin
      rd = 1; pw = 1; b = 2'b01; ir[s[1:0]] = 1'b1;
    end
    case (s)
      4'd4:  b = 2'b11;
      4'd5:  begin a = 1; b = 2'b10; end
      4'd6:  begin rd = 1; as = 1; end
      4'd7:  begin rw = 1; wb = 1; end
      4'd8:  begin wr = 1; as = 1; end
      4'd9:  begin a = 1; op = 2'b10; end
      4'd10: begin rw = 1; d = 1; end
      4'd11: begin a = 1; op = 2'b01; pwc = 1; ps = 2'b01; end
      4'd12: begin pw = 1; ps = 2'b10; end
      default: ;
    endcase
    return {rd, wr, as, ir, pw, pwc, ps, a, b, op, d, rw, wb};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [3:0] s);
    chk({req, " state"}, 32'(state_o), 32'(s));
    chk({req, " outputs"}, 32'(act_ctrl), 32'(exp_ctrl(s)));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {opcode, path length, path nibbles with the first state in the low nibble}
  localparam int NV = 8;
  localparam logic [41:0] VEC [NV] = '{
    {6'b100000, 4'd8, 32'h76543210},  // load byte: R5 R6
    {6'b101000, 4'd7, 32'h08543210},  // store byte: R5 R7
    {6'b000000, 4'd7, 32'h0A943210},  // register type: R8
    {6'b000100, 4'd6, 32'h00B43210},  // branch-equal: R9
    {6'b000010, 4'd6, 32'h00C43210},  // jump: R10
    {6'b111111, 4'd5, 32'h00043210},  // unlisted: R11
    {6'b000001, 4'd5, 32'h00043210},  // unlisted: R11
    {6'b000000, 4'd7, 32'h0A943210}   // register type again after unlisted
  };

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk_state("R1 reset", 4'd0);
    rst = 1'b0;

    // Table walk: every instruction in sequence, each state checked (R2 R3 R4 R11 R12).
    for (int v = 0; v < NV; v++) begin
      opcode = VEC[v][41:36];
      for (int k = 0; k < int'(VEC[v][35:32]); k++) begin
        chk_state($sformatf("R4 R12 vec%0d step%0d", v, k), VEC[v][4*k +: 4]);
        step();
      end
    end
    chk_state("R11 back to fetch", 4'd0);

    // R2: opcode changes during fetch have no effect; decode sees the value present then.
    for (int k = 0; k < 4; k++) begin
      opcode = (k % 2 == 0) ? 6'b100000 : 6'b111111;
      chk_state("R2 fetch ignores opcode", 4'(k));
      step();
    end
    opcode = 6'b000010;
    chk_state("R2 decode", 4'd4);
    step();
    chk_state("R10 jump", 4'd12);
    step();
    chk_state("R11 jump done", 4'd0);

    // R5: load/store choice made from opcode in the address state.
    opcode = 6'b100000;
    repeat (5) step();
    chk_state("R5 addr", 4'd5);
    opcode = 6'b101000;
    step();
    chk_state("R5 store chosen in addr", 4'd8);
    step();
    chk_state("R7 store done", 4'd0);

    // R1: reset in the middle of a load sequence.
    opcode = 6'b100000;
    repeat (6) step();
    chk_state("R6 load access", 4'd6);
    rst = 1'b1;
    step();
    chk_state("R1 mid reset", 4'd0);
    step();
    chk_state("R1 held reset", 4'd0);
    rst = 1'b0;
    step();
    chk_state("R1 resume", 4'd1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule